// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit-Slot Engine

This block is the bit-level engine of a slave on a single open-drain data line that is shared by one master and any number of slaves. It takes the raw line level and passes it through a synchroniser and an edge filter. It measures how long each low period lasts. When the line rises after a low period long enough to be a bus reset, it answers with a presence pulse. Between resets, each falling edge that the master starts becomes a bit slot. In a write slot the block samples the line at a fixed delay and reports the received bit. In a read slot it pulls the line low when the bit to send is zero.

The block runs at two speeds: standard and fast. A command layer above it asks for the fast speed with a single-cycle request. The length of the next reset decides whether the fast speed is kept. At standard speed the block also rejects line glitches. It ignores a falling edge that comes too soon after a rising edge, and it accepts a slot start only when the line is low on two consecutive synchronised samples. All time limits are counted in microsecond ticks. The ticks come from an internal prescaler of `CLKS_PER_US` clocks, which restarts at reset.

Top module: `swb_slot_engine`

## Requirements
- R1: After synchronous reset, `bus_pull` is 0 (1 means drive the line low), `rx_stb`, `tx_stb` and `rst_stb` are 0, and `od_mode` is 0 (standard speed).
- R2: When the filtered line rises after a low period of at least 440 ticks (any speed), or of at least 40 ticks while `od_mode` is 1, `rst_stb` pulses for exactly one cycle and any drive of the line stops. Shorter low periods give no `rst_stb`.
- R3: A one-cycle `od_set` sets `od_mode` to 1. A reset leaves `od_mode` at 1 only if `od_mode` was 1 and the low period was at most 80 ticks; otherwise it clears `od_mode`. When `od_set` arrives in the same cycle as a reset, the reset decides and `od_set` is ignored.
- R4: After `rst_stb`, the block waits 30 ticks (standard) or 3 ticks (fast) and then drives `bus_pull` for 120 ticks (standard) or 12 ticks (fast). The speed used is the one that the reset selected.
- R5: An accepted falling edge with `tx_valid` at 0 starts a write slot. On the 30th tick (standard) or 3rd tick (fast) after the edge, `rx_stb` pulses for one cycle. `rx_bit` then holds the line level at that moment: 1 for high, 0 for low.
- R6: An accepted falling edge with `tx_valid` at 1 starts a read slot and pulses `tx_stb` for one cycle. If `tx_bit` is 0, `bus_pull` is 1 from the next cycle for 45 ticks (standard) or 5 ticks (fast). If `tx_bit` is 1, the line is never driven.
- R7: At standard speed, a falling edge that comes fewer than 5 ticks after the previous rising edge is ignored. At fast speed no such window applies.
- R8: At standard speed a low level must be seen on two consecutive synchronised samples before it counts as a falling edge, so a one-clock low glitch starts no slot. At fast speed one low sample is enough.
- R9: Falling edges that arrive while a presence pulse is pending or active, or while a slot is still running, start no slot and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw sampled line level |
| od_set | input | 1 | One-cycle request from the command layer to enter fast speed |
| tx_valid | input | 1 | 1: the next slot is a read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| bus_pull | output | 1 | 1: enable the open-drain pull-down |
| rx_stb | output | 1 | One-cycle strobe for a received bit |
| rx_bit | output | 1 | Last received bit |
| tx_stb | output | 1 | One-cycle strobe: a read slot has taken `tx_bit` |
| rst_stb | output | 1 | One-cycle strobe: a bus reset was recognised |
| od_mode | output | 1 | 1: fast speed, 0: standard speed |

## Verification
Two functions can land in the same clock edge: recognising a reset, and a speed request from the command layer that changes `od_mode`. The bench puts the block in fast speed and sends a 200-tick low. It then raises `od_set` on exactly the edge where the filtered rising edge is evaluated. That edge is the fourth clock after the line is released, counting two synchroniser stages and the filter register. The result is correct only if `od_mode` ends at 0, because that low period sends the block back to standard speed. The behavioural model checks this on every clock, and a dedicated check confirms it as well.

// File: rtl/swb_slot_pkg.sv
package swb_slot_pkg;

  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_WSAMP,
    SLOT_RDRIVE,
    SLOT_PWAIT,
    SLOT_PLOW
  } slot_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swb_us_tick.sv
module swb_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/swb_line_filter.sv
module swb_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  input  logic fast,
  output logic line,
  output logic fall,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   line_q;
  logic                   line_d_q;
  logic                   synced;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else     sync_q[g] <= bus_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // High is taken at once; low needs two samples unless running fast.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b1;
      line_q   <= 1'b1;
      line_d_q <= 1'b1;
    end else begin
      prev_q   <= synced;
      line_q   <= synced | (~fast & prev_q & line_q);
      line_d_q <= line_q;
    end
  end

  assign line = line_q;
  assign fall = line_d_q & ~line_q;
  assign rise = ~line_d_q & line_q;
endmodule

// File: rtl/swb_len_meter.sv
module swb_len_meter #(
  parameter int LO_SAT = 440,
  parameter int HI_SAT = 5,
  localparam int LOW_W = $clog2(LO_SAT + 2),
  localparam int HIW_W = $clog2(HI_SAT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line,
  input  logic             fall,
  input  logic             rise,
  input  logic             tick,
  output logic [LOW_W-1:0] lo_cnt,
  output logic [HIW_W-1:0] hi_cnt
);
  localparam logic [LOW_W-1:0] LO_TOP = LOW_W'(LO_SAT);
  localparam logic [HIW_W-1:0] HI_TOP = HIW_W'(HI_SAT);

  logic [LOW_W-1:0] lo_q;
  logic [HIW_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= HI_TOP;
    end else begin
      if (fall)
        lo_q <= '0;
      else if (!line && tick && lo_q != LO_TOP)
        lo_q <= lo_q + LOW_W'(1);

      if (rise)
        hi_q <= '0;
      else if (line && tick && hi_q != HI_TOP)
        hi_q <= hi_q + HIW_W'(1);
    end
  end

  assign lo_cnt = lo_q;
  assign hi_cnt = hi_q;
endmodule

// File: rtl/swb_slot_engine.sv
module swb_slot_engine
  import swb_slot_pkg::*;
#(
  parameter int CLKS_PER_US  = 50,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STD_US   = 440,
  parameter int RST_OD_US    = 40,
  parameter int OD_KEEP_US   = 80,
  parameter int SAMP_STD_US  = 30,
  parameter int SAMP_OD_US   = 3,
  parameter int RHOLD_STD_US = 45,
  parameter int RHOLD_OD_US  = 5,
  parameter int PDH_STD_US   = 30,
  parameter int PDH_OD_US    = 3,
  parameter int PDL_STD_US   = 120,
  parameter int PDL_OD_US    = 12,
  parameter int HOLDOFF_US   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  input  logic od_set,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic bus_pull,
  output logic rx_stb,
  output logic rx_bit,
  output logic tx_stb,
  output logic rst_stb,
  output logic od_mode
);
  localparam int TMAX  = max_of(max_of(max_of(SAMP_STD_US, SAMP_OD_US), max_of(RHOLD_STD_US, RHOLD_OD_US)),
                                max_of(max_of(PDH_STD_US, PDH_OD_US), max_of(PDL_STD_US, PDL_OD_US)));
  localparam int TW    = $clog2(TMAX + 2);
  localparam int LOW_W = $clog2(RST_STD_US + 2);
  localparam int HIW_W = $clog2(HOLDOFF_US + 2);

  localparam logic [LOW_W-1:0] LIM_RST_STD = LOW_W'(RST_STD_US);
  localparam logic [LOW_W-1:0] LIM_RST_OD  = LOW_W'(RST_OD_US);
  localparam logic [LOW_W-1:0] LIM_OD_KEEP = LOW_W'(OD_KEEP_US);
  localparam logic [HIW_W-1:0] LIM_HOLD    = HIW_W'(HOLDOFF_US);

  logic             tick;
  logic             line, fall, rise;
  logic [LOW_W-1:0] lo_cnt;
  logic [HIW_W-1:0] hi_cnt;

  slot_state_e      st_q;
  logic [TW-1:0]    tmr_q;
  logic [TW-1:0]    cur_lim;
  logic             tmr_hit;
  logic             rst_hit;
  logic             in_hold;
  logic             od_q, pull_q;
  logic             rx_stb_q, rx_bit_q, tx_stb_q, rst_stb_q;

  swb_us_tick #(.DIV(CLKS_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  swb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .bus_in (bus_in),
    .fast   (od_q),
    .line   (line),
    .fall   (fall),
    .rise   (rise)
  );

  swb_len_meter #(.LO_SAT(RST_STD_US), .HI_SAT(HOLDOFF_US)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .line   (line),
    .fall   (fall),
    .rise   (rise),
    .tick   (tick),
    .lo_cnt (lo_cnt),
    .hi_cnt (hi_cnt)
  );

  // Phase length for the current state at the current speed.
  always_comb begin
    case (st_q)
      SLOT_WSAMP:  cur_lim = od_q ? TW'(SAMP_OD_US)  : TW'(SAMP_STD_US);
      SLOT_RDRIVE: cur_lim = od_q ? TW'(RHOLD_OD_US) : TW'(RHOLD_STD_US);
      SLOT_PWAIT:  cur_lim = od_q ? TW'(PDH_OD_US)   : TW'(PDH_STD_US);
      SLOT_PLOW:   cur_lim = od_q ? TW'(PDL_OD_US)   : TW'(PDL_STD_US);
      default:     cur_lim = TW'(1);
    endcase
  end

  assign tmr_hit = tick && ((tmr_q + TW'(1)) == cur_lim);
  assign rst_hit = rise && ((lo_cnt >= LIM_RST_STD) || (od_q && lo_cnt >= LIM_RST_OD));
  assign in_hold = !od_q && (hi_cnt < LIM_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SLOT_IDLE;
      tmr_q     <= '0;
      od_q      <= 1'b0;
      pull_q    <= 1'b0;
      rx_stb_q  <= 1'b0;
      rx_bit_q  <= 1'b0;
      tx_stb_q  <= 1'b0;
      rst_stb_q <= 1'b0;
    end else begin
      rx_stb_q  <= 1'b0;
      tx_stb_q  <= 1'b0;
      rst_stb_q <= 1'b0;
      if (rst_hit) begin
        rst_stb_q <= 1'b1;
        od_q      <= od_q && (lo_cnt <= LIM_OD_KEEP);
        pull_q    <= 1'b0;
        st_q      <= SLOT_PWAIT;
        tmr_q     <= '0;
      end else begin
        if (od_set) od_q <= 1'b1;
        case (st_q)
          SLOT_IDLE: begin
            if (fall && !in_hold) begin
              tmr_q <= '0;
              if (tx_valid) begin
                tx_stb_q <= 1'b1;
                if (!tx_bit) begin
                  pull_q <= 1'b1;
                  st_q   <= SLOT_RDRIVE;
                end
              end else begin
                st_q <= SLOT_WSAMP;
              end
            end
          end
          default: begin
            if (tmr_hit) begin
              tmr_q <= '0;
              case (st_q)
                SLOT_WSAMP: begin
                  rx_stb_q <= 1'b1;
                  rx_bit_q <= line;
                  st_q     <= SLOT_IDLE;
                end
                SLOT_PWAIT: begin
                  pull_q <= 1'b1;
                  st_q   <= SLOT_PLOW;
                end
                default: begin
                  pull_q <= 1'b0;
                  st_q   <= SLOT_IDLE;
                end
              endcase
            end else if (tick) begin
              tmr_q <= tmr_q + TW'(1);
            end
          end
        endcase
      end
    end
  end

  assign bus_pull = pull_q;
  assign rx_stb   = rx_stb_q;
  assign rx_bit   = rx_bit_q;
  assign tx_stb   = tx_stb_q;
  assign rst_stb  = rst_stb_q;
  assign od_mode  = od_q;
endmodule

// File: rtl/swb_slot_engine_chk.sv
module swb_slot_engine_chk (
  input logic clk,
  input logic rst,
  input logic od_set,
  input logic bus_pull,
  input logic rx_stb,
  input logic tx_stb,
  input logic rst_stb,
  input logic od_mode
);
  assert_rst_single_R2: assert property (@(posedge clk) disable iff (rst)
    rst_stb |=> !rst_stb);

  assert_rst_release_R2: assert property (@(posedge clk) disable iff (rst)
    rst_stb |-> !bus_pull);

  assert_od_enter_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(od_mode) |-> $past(od_set));

  assert_od_leave_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(od_mode) |-> rst_stb);

  assert_rx_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> !rx_stb);
endmodule

bind swb_slot_engine swb_slot_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .od_set   (od_set),
  .bus_pull (bus_pull),
  .rx_stb   (rx_stb),
  .tx_stb   (tx_stb),
  .rst_stb  (rst_stb),
  .od_mode  (od_mode)
);

// File: tb/sim_swb_slot_engine.sv
`timescale 1ns/1ps
module sim_swb_slot_engine;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mlow = 1'b0;
  logic od_set = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_in;
  logic bus_pull, rx_stb, rx_bit, tx_stb, rst_stb, od_mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign bus_in = !(mlow || bus_pull);

  swb_slot_engine #(.CLKS_PER_US(N)) u0 (
    .clk(clk), .rst(rst), .bus_in(bus_in), .od_set(od_set),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .bus_pull(bus_pull),
    .rx_stb(rx_stb), .rx_bit(rx_bit), .tx_stb(tx_stb),
    .rst_stb(rst_stb), .od_mode(od_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model (times in ticks of N clocks)
  int  m_pre, m_lo, m_hi, m_st, m_tm, lim;
  bit  m_s1, m_s2, m_s3, m_ln, m_lnd, m_od;
  bit  e_pull, e_rx, e_rxb, e_tx, e_rst;
  bit  b, fl, rs, tk, hold, odo, nln;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_ln = 1; m_lnd = 1; m_od = 0;
      m_pre = 0; m_lo = 0; m_hi = 5; m_st = 0; m_tm = 0;
      e_pull = 0; e_rx = 0; e_rxb = 0; e_tx = 0; e_rst = 0;
    end else begin
      b = !(mlow || e_pull);
      fl = m_lnd && !m_ln;
      rs = !m_lnd && m_ln;
      tk = (m_pre == N - 1);
      odo = m_od;
      hold = !odo && (m_hi < 5);
      e_rx = 0; e_tx = 0; e_rst = 0;
      if (rs && (m_lo >= 440 || (odo && m_lo >= 40))) begin
        e_rst = 1; m_od = odo && (m_lo <= 80); m_st = 3; m_tm = 0; e_pull = 0;
      end else begin
        if (od_set) m_od = 1;
        if (m_st == 0) begin
          if (fl && !hold) begin
            m_tm = 0;
            if (tx_valid) begin
              e_tx = 1;
              if (!tx_bit) begin e_pull = 1; m_st = 2; end
            end else m_st = 1;
          end
        end else if (tk) begin
          case (m_st)
            1: lim = odo ? 3 : 30;
            2: lim = odo ? 5 : 45;
            3: lim = odo ? 3 : 30;
            default: lim = odo ? 12 : 120;
          endcase
          if (m_tm + 1 == lim) begin
            m_tm = 0;
            case (m_st)
              1: begin e_rx = 1; e_rxb = m_ln; m_st = 0; end
              3: begin e_pull = 1; m_st = 4; end
              default: begin e_pull = 0; m_st = 0; end
            endcase
          end else m_tm++;
        end
      end
      if (fl) m_lo = 0; else if (!m_ln && tk && m_lo < 440) m_lo++;
      if (rs) m_hi = 0; else if (m_ln && tk && m_hi < 5) m_hi++;
      m_pre = tk ? 0 : m_pre + 1;
      nln = m_s2 ? 1 : (odo ? 0 : (m_s3 ? m_ln : 0));
      m_lnd = m_ln; m_ln = nln; m_s3 = m_s2; m_s2 = m_s1; m_s1 = b;
    end
  end

  // Per-clock comparison and event counters
  int n_rst = 0, n_rx = 0, n_tx = 0, n_prise = 0, last_rxb = 0;
  bit prev_pull = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_pull == e_pull, "R4,R6 bus_pull", bus_pull, e_pull);
      chk(rx_stb == e_rx, "R5 rx_stb", rx_stb, e_rx);
      chk(rx_bit == e_rxb, "R5 rx_bit", rx_bit, e_rxb);
      chk(tx_stb == e_tx, "R6 tx_stb", tx_stb, e_tx);
      chk(rst_stb == e_rst, "R2 rst_stb", rst_stb, e_rst);
      chk(od_mode == m_od, "R3 od_mode", od_mode, m_od);
      if (rst_stb) n_rst++;
      if (tx_stb) n_tx++;
      if (rx_stb) begin n_rx++; last_rxb = rx_bit; end
      if (bus_pull && !prev_pull) n_prise++;
      prev_pull = bus_pull;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic us(input int n);
    repeat (n * N) step();
  endtask

  task automatic low(input int n);
    mlow = 1'b1;
    us(n);
    mlow = 1'b0;
  endtask

  task automatic clr();
    n_rst = 0; n_rx = 0; n_tx = 0; n_prise = 0;
  endtask

  task automatic pulse_od();
    od_set = 1'b1;
    step();
    od_set = 1'b0;
  endtask

  initial begin
    repeat (5) step();
    rst = 1'b0;
    step();
    chk(bus_pull == 0, "R1 bus_pull", bus_pull, 0);
    chk(od_mode == 0, "R1 od_mode", od_mode, 0);
    chk(!rx_stb && !tx_stb && !rst_stb, "R1 strobes", rx_stb + tx_stb + rst_stb, 0);
    us(20);

    // R2/R4 standard reset with presence
    low(500); clr(); us(200);
    chk(n_rst == 1, "R2 std reset", n_rst, 1);
    chk(n_prise == 1, "R4 std presence", n_prise, 1);

    // R5 standard write slots
    clr(); low(6); us(64);
    chk(n_rx == 1 && last_rxb == 1, "R5 std write one", last_rxb, 1);
    clr(); low(70); us(10);
    chk(n_rx == 1 && last_rxb == 0, "R5 std write zero", last_rxb, 0);

    // R6 standard read slots
    tx_valid = 1; tx_bit = 0;
    clr(); low(2); us(80);
    chk(n_tx == 1 && n_prise == 1, "R6 std read zero", n_prise, 1);
    tx_bit = 1;
    clr(); low(2); us(70);
    chk(n_tx == 1 && n_prise == 0, "R6 std read one", n_prise, 0);

    // R7 hold-off at standard speed
    clr(); low(2); us(2); low(2); us(70);
    chk(n_tx == 1, "R7 holdoff drops edge", n_tx, 1);
    clr(); low(2); us(10); low(2); us(70);
    chk(n_tx == 2, "R7 edge after holdoff", n_tx, 2);
    tx_valid = 0;

    // R8 one-clock glitch at standard speed
    clr(); mlow = 1; step(); mlow = 0; us(60);
    chk(n_rx == 0, "R8 std glitch", n_rx, 0);

    // R9 edge during pending presence
    low(500); clr(); us(10); low(2); us(200);
    chk(n_rx == 0 && n_tx == 0, "R9 no slot in presence", n_rx + n_tx, 0);
    chk(n_rst == 1 && n_prise == 1, "R9 presence intact", n_prise, 1);

    // R3 enter fast speed
    pulse_od();
    chk(od_mode == 1, "R3 od_set", od_mode, 1);

    clr(); low(1); us(8);
    chk(n_rx == 1 && last_rxb == 1, "R5 fast write one", last_rxb, 1);
    clr(); low(8); us(3);
    chk(n_rx == 1 && last_rxb == 0, "R5 fast write zero", last_rxb, 0);

    tx_valid = 1; tx_bit = 0;
    clr(); low(1); us(10);
    chk(n_tx == 1 && n_prise == 1, "R6 fast read zero", n_prise, 1);
    tx_bit = 1;
    clr(); low(1); us(2); low(1); us(10);
    chk(n_tx == 2, "R7 no holdoff fast", n_tx, 2);
    tx_valid = 0;

    clr(); mlow = 1; step(); mlow = 0; us(10);
    chk(n_rx == 1 && last_rxb == 1, "R8 fast single sample", n_rx, 1);

    // R3 short reset keeps fast speed
    clr(); low(60); clr(); us(40);
    chk(n_rst == 1, "R2 fast reset", n_rst, 1);
    chk(od_mode == 1, "R3 short reset keeps", od_mode, 1);
    chk(n_prise == 1, "R4 fast presence", n_prise, 1);

    // R3 mid-length reset returns to standard
    low(200); clr(); us(200);
    chk(n_rst == 1 && od_mode == 0, "R3 mid reset std", od_mode, 0);

    // R3 od_set in the same cycle as reset recognition
    pulse_od(); us(5);
    low(200);
    repeat (3) step();
    od_set = 1; step(); od_set = 0;
    clr(); us(200);
    chk(od_mode == 0, "R3 reset beats od_set", od_mode, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule